// File: doc/BRIEF.md
# Quadruple-Precision Round and Pack

This block takes an unpacked binary floating-point value and turns it into a 128-bit quadruple-precision word, together with exception flags. The value arrives as a sign, a signed 32-bit exponent that is one less than the true exponent, and a 113-bit significand spread over two 64-bit words. A third 64-bit word holds the bits below the significand's LSB, with the round bit in its MSB and the lower bits acting as sticky.

It is used at the end of an arithmetic datapath, after normalization. The block does the following:
- applies one of four rounding modes;
- saturates on overflow, to infinity or to the largest finite value;
- shifts tiny values into subnormal form with sticky jamming;
- detects tininess either before or after rounding.

The packed exponent field is added onto the significand's integer bit, not inserted over it. As a result, an input exponent one below the true value packs correctly, and a rounding carry moves up into the exponent field. The result and flags are registered, so they appear one clock after the inputs.

Top module: `quad_round_pack`

## Requirements
- R1: While `rst` is high at a clock edge, `result_o` and `flags_o` become zero. Otherwise the result for the inputs present at a rising edge appears on the outputs right after that edge.
- R2: For a result that neither overflows nor is denormalized, the low output word equals the low significand word. The high output word is the 64-bit sum of the sign shifted to bit 63, the exponent shifted to bit 48, and the high significand word, so a carry out of the significand raises the exponent field. If no increment occurs and both significand words are zero, the exponent used is 0.
- R3: In mode 0 (nearest-even), an increment of 1 to the 128-bit significand is due when bit 63 of the extra word is set. When the extra word is exactly 0x8000_0000_0000_0000, bit 0 of the incremented significand is cleared.
- R4: In mode 1 (toward zero), no increment ever occurs. In mode 2 (toward minus infinity), an increment occurs only for a negative sign with a non-zero extra word. In mode 3 (toward plus infinity), an increment occurs only for a positive sign with a non-zero extra word.
- R5: Overflow occurs when the signed exponent exceeds 0x7FFD. It also occurs when the exponent equals 0x7FFD, the significand is all ones (high word 0x0001_FFFF_FFFF_FFFF, low word all ones) and an increment is due under R3 or R4.
- R6: On overflow, flag bits 3 (overflow) and 5 (inexact) are set and bit 4 is clear. The result is the largest finite magnitude (exponent field 0x7FFE, all fraction bits set, input sign) in mode 1, in mode 2 for a positive sign, and in mode 3 for a negative sign. In every other case the result is infinity with the input sign (exponent field 0x7FFF, zero fraction).
- R7: For a negative exponent, `tiny_before_i` = 1 selects before-rounding detection, and the value is always tiny. With `tiny_before_i` = 0 (after-rounding), the value is tiny when any of these holds: the exponent is below -1, no increment is due on the original extra word, or the 113-bit significand is below the all-ones pattern.
- R8: For a negative exponent, the 192-bit concatenation of the two significand words and the extra word is shifted right by the negated exponent. Any non-zero bit shifted out is OR-ed into bit 0 of the new extra word. A shift of 192 or more leaves zero significand words and an extra word of 1 if any input bit was set. The exponent becomes 0, and the increment is decided again from the shifted extra word.
- R9: Flag bit 4 (underflow) is set only when the value is tiny under R7 and the shifted extra word is non-zero.
- R10: Flag bit 5 (inexact) is set whenever the final extra word is non-zero or overflow occurs. Flag bits 0 to 2 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sign_i | input | 1 | Sign of the value (1 = negative) |
| exp_i | input | 32 | Signed exponent, one below the true exponent |
| sig_hi_i | input | 64 | Upper significand word (integer bit at bit 48) |
| sig_lo_i | input | 64 | Lower significand word |
| extra_i | input | 64 | Round and sticky bits below the significand |
| rmode_i | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity |
| tiny_before_i | input | 1 | Tininess detection: 1 before rounding, 0 after rounding |
| result_o | output | 128 | Packed quadruple-precision result, registered |
| flags_o | output | 6 | Exception flags, registered: bit 3 overflow, bit 4 underflow, bit 5 inexact |

## Verification
The hardest point to reach is exponent -1 with an all-ones significand and an increment due. Only there do the two tininess settings give different underflow flags, while the rounded result is the same. The second hard point is exponent 0x7FFD with an all-ones significand, where the outcome depends on the increment alone. The stimulus drives these exact input patterns directly, together with the values just beside them. Every such pattern is swept over all four rounding modes, both tininess settings and both signs, and the results are compared with an arithmetic model in the bench that performs the denormalizing shift one bit at a time.

// File: rtl/qrp_pkg.sv
package qrp_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_DOWN = 2'd2,
    RM_UP   = 2'd3
  } rmode_e;

  localparam int FLAG_W  = 6;
  localparam int FLG_OVF = 3;
  localparam int FLG_UNF = 4;
  localparam int FLG_INX = 5;

endpackage

// File: rtl/qrp_inc_decide.sv
module qrp_inc_decide
  import qrp_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  rmode_e            rmode_i,
  input  logic              sign_i,
  input  logic [WORD_W-1:0] extra_i,
  output logic              inc_o
);

  logic any_extra;
  assign any_extra = |extra_i;

  always_comb begin
    unique case (rmode_i)
      RM_NEAR: inc_o = extra_i[WORD_W-1];
      RM_ZERO: inc_o = 1'b0;
      RM_DOWN: inc_o = sign_i && any_extra;
      default: inc_o = !sign_i && any_extra;
    endcase
  end

endmodule

// File: rtl/qrp_jam_shift.sv
module qrp_jam_shift #(
  parameter int WORD_W = 64,
  parameter int CNT_W  = 32
) (
  input  logic [WORD_W-1:0] hi_i,
  input  logic [WORD_W-1:0] lo_i,
  input  logic [WORD_W-1:0] ext_i,
  input  logic [CNT_W-1:0]  amt_i,
  output logic [WORD_W-1:0] hi_o,
  output logic [WORD_W-1:0] lo_o,
  output logic [WORD_W-1:0] ext_o
);

  localparam int TOT   = 3 * WORD_W;
  localparam int SAT_W = $clog2(TOT + 1);

  logic [TOT-1:0]   whole;
  logic [TOT-1:0]   moved;
  logic [TOT-1:0]   lost_mask;
  logic [SAT_W-1:0] amt_s;
  logic             sat;
  logic             sticky;

  assign whole = {hi_i, lo_i, ext_i};
  assign sat   = (amt_i >= CNT_W'(TOT));
  assign amt_s = amt_i[SAT_W-1:0];

  always_comb begin
    if (sat) begin
      moved     = '0;
      lost_mask = '1;
    end else begin
      moved     = whole >> amt_s;
      lost_mask = ~({TOT{1'b1}} << amt_s);
    end
    sticky = |(whole & lost_mask);
  end

  assign hi_o  = moved[TOT-1 -: WORD_W];
  assign lo_o  = moved[2*WORD_W-1 -: WORD_W];
  assign ext_o = {moved[WORD_W-1:1], moved[0] | sticky};

endmodule

// File: rtl/quad_round_pack.sv
module quad_round_pack
  import qrp_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int EXP_W  = 32,
  parameter int FEXP_W = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sign_i,
  input  logic [EXP_W-1:0]    exp_i,
  input  logic [WORD_W-1:0]   sig_hi_i,
  input  logic [WORD_W-1:0]   sig_lo_i,
  input  logic [WORD_W-1:0]   extra_i,
  input  logic [1:0]          rmode_i,
  input  logic                tiny_before_i,
  output logic [2*WORD_W-1:0] result_o,
  output logic [FLAG_W-1:0]   flags_o
);

  localparam int FRAC_HI_W = WORD_W - FEXP_W - 1;
  localparam int SIG_W2    = 2 * WORD_W;
  localparam int SH_TOT    = 3 * WORD_W;
  localparam logic [FEXP_W-1:0] EXP_INF = {FEXP_W{1'b1}};
  localparam logic [FEXP_W-1:0] EXP_MAXF = EXP_INF - FEXP_W'(1);
  localparam logic signed [EXP_W-1:0] OVF_EXP = EXP_W'((1 << FEXP_W) - 3);
  localparam logic signed [EXP_W-1:0] NEG_ONE = '1;
  localparam logic [WORD_W-1:0] HI_ONES =
    {{(WORD_W-FRAC_HI_W-1){1'b0}}, {(FRAC_HI_W+1){1'b1}}};
  localparam logic [WORD_W-1:0] HALF_EXT = {1'b1, {(WORD_W-1){1'b0}}};

  rmode_e rm;
  assign rm = rmode_e'(rmode_i);

  logic signed [EXP_W-1:0] e_s;
  assign e_s = $signed(exp_i);

  // increment deciders: [0] on the raw extra word, [1] after denormalization
  logic [WORD_W-1:0] dec_ext [2];
  logic [1:0]        dec_inc;
  logic [WORD_W-1:0] w_ext;

  assign dec_ext[0] = extra_i;
  assign dec_ext[1] = w_ext;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    qrp_inc_decide #(.WORD_W(WORD_W)) u_dec (
      .rmode_i (rm),
      .sign_i  (sign_i),
      .extra_i (dec_ext[g]),
      .inc_o   (dec_inc[g])
    );
  end

  logic inc_pre, inc_fin;
  assign inc_pre = dec_inc[0];
  assign inc_fin = dec_inc[1];

  // overflow and tininess
  logic sig_full, sig_below, exp_neg, ovf_c, tiny_c;
  assign sig_full  = (sig_hi_i == HI_ONES) && (&sig_lo_i);
  assign sig_below = {sig_hi_i, sig_lo_i} < {HI_ONES, {WORD_W{1'b1}}};
  assign exp_neg   = e_s < 0;
  assign ovf_c     = (e_s > OVF_EXP) || ((e_s == OVF_EXP) && sig_full && inc_pre);
  assign tiny_c    = exp_neg && (tiny_before_i || (e_s < NEG_ONE) || !inc_pre || sig_below);

  // denormalization
  logic [EXP_W-1:0]  amt;
  logic [WORD_W-1:0] sh_hi, sh_lo, sh_ext;
  assign amt = exp_neg ? (EXP_W'(0) - exp_i) : '0;

  qrp_jam_shift #(.WORD_W(WORD_W), .CNT_W(EXP_W)) u_shift (
    .hi_i  (sig_hi_i),
    .lo_i  (sig_lo_i),
    .ext_i (extra_i),
    .amt_i (amt),
    .hi_o  (sh_hi),
    .lo_o  (sh_lo),
    .ext_o (sh_ext)
  );

  logic [SIG_W2-1:0] w_sig;
  logic [EXP_W-1:0]  w_exp;
  assign w_sig = exp_neg ? {sh_hi, sh_lo} : {sig_hi_i, sig_lo_i};
  assign w_ext = exp_neg ? sh_ext : extra_i;
  assign w_exp = exp_neg ? '0 : exp_i;

  // rounding and packing
  logic [SIG_W2-1:0] sig_up, fin_sig;
  logic [EXP_W-1:0]  fin_exp;
  logic [WORD_W-1:0] hi_word;
  logic              tie;

  assign tie = (rm == RM_NEAR) && (w_ext == HALF_EXT);

  always_comb begin
    sig_up = w_sig + SIG_W2'(1);
    if (tie) sig_up[0] = 1'b0;
    fin_sig = inc_fin ? sig_up : w_sig;
    fin_exp = (!inc_fin && (w_sig == '0)) ? '0 : w_exp;
    hi_word = {sign_i, {(WORD_W-1){1'b0}}}
            + (WORD_W'(fin_exp) << FRAC_HI_W)
            + fin_sig[SIG_W2-1:WORD_W];
  end

  logic [SIG_W2-1:0] res_c;
  logic [FLAG_W-1:0] flg_c;
  logic              to_maxf;

  assign to_maxf = (rm == RM_ZERO) || (sign_i && (rm == RM_UP)) || (!sign_i && (rm == RM_DOWN));

  always_comb begin
    flg_c = '0;
    if (ovf_c) begin
      flg_c[FLG_OVF] = 1'b1;
      flg_c[FLG_INX] = 1'b1;
      if (to_maxf)
        res_c = {sign_i, EXP_MAXF, {FRAC_HI_W{1'b1}}, {WORD_W{1'b1}}};
      else
        res_c = {sign_i, EXP_INF, {(SIG_W2-1-FEXP_W){1'b0}}};
    end else begin
      flg_c[FLG_UNF] = tiny_c && (sh_ext != '0);
      flg_c[FLG_INX] = (w_ext != '0);
      res_c = {hi_word, fin_sig[WORD_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      result_o <= res_c;
      flags_o  <= flg_c;
    end
  end

  // R4
  rtz_no_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (rm == RM_ZERO) |-> !inc_pre);

  // R5
  ovf_range_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_c |-> (e_s >= OVF_EXP));

  // R6
  ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    flags_o[FLG_OVF] |-> (flags_o[FLG_INX] && !flags_o[FLG_UNF]));

  // R6
  rtz_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_o[FLG_OVF] && ($past(rmode_i) == 2'd1)) |-> (result_o[SIG_W2-2 -: FEXP_W] == EXP_MAXF));

  // R8
  shift_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (exp_neg && (amt >= EXP_W'(SH_TOT))) |-> ((sh_hi == '0) && (sh_lo == '0)));

  // R9
  unf_inx_chk: assert property (@(posedge clk) disable iff (rst)
    flags_o[FLG_UNF] |-> flags_o[FLG_INX]);

endmodule

// File: tb/quad_round_pack_tb_top.sv
module quad_round_pack_tb_top;

  localparam int CLK_T = 10;
  localparam logic [63:0] H1   = 64'h0001_0000_0000_0000;
  localparam logic [63:0] HF   = 64'h0001_FFFF_FFFF_FFFF;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] HALF = 64'h8000_0000_0000_0000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sign_i = 1'b0;
  logic [31:0]  exp_i = '0;
  logic [63:0]  sig_hi_i = '0, sig_lo_i = '0, extra_i = '0;
  logic [1:0]   rmode_i = '0;
  logic         tiny_before_i = 1'b0;
  logic [127:0] result_o;
  logic [5:0]   flags_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_T/2) clk = ~clk;

  quad_round_pack dut_i (
    .clk(clk), .rst(rst), .sign_i(sign_i), .exp_i(exp_i),
    .sig_hi_i(sig_hi_i), .sig_lo_i(sig_lo_i), .extra_i(extra_i),
    .rmode_i(rmode_i), .tiny_before_i(tiny_before_i),
    .result_o(result_o), .flags_o(flags_o)
  );

  function automatic logic want_inc(input int rm, input logic s, input logic [63:0] x);
    case (rm)
      0:       return x[63];
      1:       return 1'b0;
      2:       return s && (x != 0);
      default: return !s && (x != 0);
    endcase
  endfunction

  function automatic logic [133:0] ref_model(input logic s, input int e, input logic [63:0] h,
                                             input logic [63:0] l, input logic [63:0] x,
                                             input int rm, input logic tb);
    logic         inc, tiny, stk;
    logic [191:0] v;
    logic [127:0] sig;
    logic [63:0]  hw;
    logic [5:0]   f;
    int           cnt;
    inc = want_inc(rm, s, x);
    if (e > 32'sh7FFD || (e == 32'sh7FFD && h == HF && l == ONES && inc)) begin
      f = 6'h28;
      if (rm == 1 || (s && rm == 3) || (!s && rm == 2))
        return {f, s, 15'h7FFE, 48'hFFFF_FFFF_FFFF, ONES};
      return {f, s, 15'h7FFF, 112'h0};
    end
    f = '0;
    if (e < 0) begin
      tiny = tb || (e < -1) || !inc || ({h, l} < {HF, ONES});
      cnt  = (e < -193) ? 193 : -e;
      v    = {h, l, x};
      stk  = 1'b0;
      for (int i = 0; i < cnt; i++) begin
        stk = stk | v[0];
        v   = v >> 1;
      end
      v[0] = v[0] | stk;
      h = v[191:128]; l = v[127:64]; x = v[63:0];
      e = 0;
      inc = want_inc(rm, s, x);
      if (tiny && x != 0) f[4] = 1'b1;
    end
    if (x != 0) f[5] = 1'b1;
    sig = {h, l};
    if (inc) begin
      sig = sig + 128'd1;
      if (rm == 0 && x == HALF) sig[0] = 1'b0;
    end else if (sig == 0) begin
      e = 0;
    end
    hw = {s, 63'b0} + (64'(e) << 48) + sig[127:64];
    return {f, hw, sig[63:0]};
  endfunction

  task automatic chk(input string tag, input logic [133:0] got, input logic [133:0] exp_v);
    n_chk++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp_v);
    end
  endtask

  task automatic run_vec(input string tag, input logic s, input int e, input logic [63:0] h,
                         input logic [63:0] l, input logic [63:0] x, input int rm, input logic tb);
    @(negedge clk);
    sign_i = s; exp_i = e; sig_hi_i = h; sig_lo_i = l; extra_i = x;
    rmode_i = rm[1:0]; tiny_before_i = tb;
    @(negedge clk);
    chk(tag, {flags_o, result_o}, ref_model(s, e, h, l, x, rm, tb));
    // R10: unused flag bits stay clear
    chk("R10", {131'b0, flags_o[2:0]}, 134'b0);
  endtask

  task automatic sweep(input string tag, input int e, input logic [63:0] h,
                       input logic [63:0] l, input logic [63:0] x);
    for (int rm = 0; rm < 4; rm++)
      for (int tb = 0; tb < 2; tb++)
        for (int s = 0; s < 2; s++)
          run_vec(tag, s[0], e, h, l, x, rm, tb[0]);
  endtask

  initial begin
    #(CLK_T * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: outputs held at zero in reset despite active inputs
    sign_i = 1'b1; exp_i = 32'h3FFF; sig_hi_i = HF; extra_i = ONES; rmode_i = 2'd3;
    repeat (3) @(negedge clk);
    chk("R1", {flags_o, result_o}, 134'b0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: first result one edge after release
    chk("R1", {flags_o, result_o}, ref_model(1'b1, 32'h3FFF, HF, 64'h0, ONES, 3, 1'b0));

    // R2: exact packing, zero significand, carry into the exponent
    sweep("R2", 32'sh3FFF, H1, 64'h0, 64'h0);
    sweep("R2", 5, 64'h0, 64'h0, 64'h0);
    sweep("R2", 32'sh3FFE, HF, ONES, HALF);
    // R3: ties, just above and just below half
    sweep("R3", 32'sh4000, H1, 64'h2, HALF);
    sweep("R3", 32'sh4000, H1, 64'h3, HALF);
    sweep("R3", 32'sh4000, H1, 64'h2, HALF | 64'h1);
    sweep("R3", 32'sh4000, H1, 64'h3, HALF - 64'h1);
    // R4: directed modes with small and large extra words
    sweep("R4", 32'sh1234, H1 | 64'h5, 64'h9, 64'h1);
    sweep("R4", 32'sh1234, H1, 64'h0, ONES);
    // R5: overflow boundary
    sweep("R5", 32'sh7FFD, HF, ONES, HALF);
    sweep("R5", 32'sh7FFD, HF, ONES, 64'h0);
    sweep("R5", 32'sh7FFD, HF, ONES, 64'h1);
    sweep("R5", 32'sh7FFD, HF, ONES - 64'h1, ONES);
    sweep("R5", 32'sh7FFC, HF, ONES, ONES);
    // R6: clear overflow by exponent
    sweep("R6", 32'sh7FFE, H1, 64'h0, 64'h0);
    sweep("R6", 32'sh7FFFFFFF, H1, 64'h0, 64'h0);
    sweep("R6", 32'sh8000, H1, 64'h5, 64'h7);
    // R7: tininess boundary at exponent -1
    sweep("R7", -1, HF, ONES, HALF);
    sweep("R7", -1, HF, ONES, ONES);
    sweep("R7", -1, HF, ONES - 64'h1, HALF);
    sweep("R7", -2, HF, ONES, ONES);
    // R8: denormalizing shifts including saturation
    sweep("R8", -5, H1, 64'h3, 64'h0);
    sweep("R8", -113, H1, 64'h0, 64'h0);
    sweep("R8", -150, HF, ONES, 64'h0);
    sweep("R8", -191, H1, 64'h0, 64'h0);
    sweep("R8", -192, H1, 64'h0, 64'h0);
    sweep("R8", -300, H1, 64'h0, 64'h0);
    sweep("R8", 32'sh80000000, HF, ONES, ONES);
    // R9: exact and inexact one-bit denormalization
    sweep("R9", -1, H1, 64'h0, 64'h0);
    sweep("R9", -1, H1, 64'h1, 64'h0);

    // R4 / R10: random values over all exponent regions
    for (int k = 0; k < 1500; k++) begin
      logic [63:0] h, l, x;
      int e;
      int sel;
      h = {15'b0, 1'b1, {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF};
      l = {$urandom, $urandom};
      x = {$urandom, $urandom};
      if ($urandom % 4 == 0) x = x & 64'hFF;
      sel = int'($urandom % 5);
      case (sel)
        0: e = int'($urandom % 32'h7FFC) + 1;
        1: e = 32'sh7FFA + int'($urandom % 6);
        2: e = -1 - int'($urandom % 8);
        3: e = -1 - int'($urandom % 220);
        default: e = int'($urandom % 64);
      endcase
      run_vec("R4", $urandom % 2 == 1, e, h, l, x, int'($urandom % 4), $urandom % 2 == 1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule